// File: doc/BRIEF.md
# Multicycle Microcontroller Core with Serial Byte Output

This block is a small programmable core. It steps through a program held in a parameterized instruction ROM and keeps its results in an eight-entry register file. Every instruction takes a fixed sequence of four states: fetch, decode, execute and write-back. The core has no branches, so the program counter only ever moves forward by one.

One instruction hands a register value to a built-in 8N1 serial transmitter. The bit period of that transmitter is set at run time through a 16-bit divider input. A halt instruction freezes the core and raises a status flag. The contents of R7 are always visible on a parallel output, which lets a host check both the serial byte and the final register value after the program stops.

The default program computes Fibonacci(6) = 8 into R7. It then adds 0x30 to that result and sends the character '8' (0x38) on the serial line before it halts.

Top module: `mcu_core`

## Requirements
- R1: Each instruction moves through FETCH, DECODE, EXECUTE and WRITEBACK in that order. Except during a serial stall, an instruction takes exactly 4 clocks, and the program counter changes only when WRITEBACK ends.
- R2: While rst_ni is low, pc_o is 0, r7_o is 0, halted_o is 0 and tx_o is 1. All registers are cleared.
- R3: After reset the core waits in an idle state and fetches nothing until start_i is high. Once start_i is high, the first fetch begins on the next clock.
- R4: The instruction word is 16 bits: opcode in [15:12], Rd in [11:9], Ra in [8:6], Rb in [5:3], and an 8-bit immediate in [7:0]. Opcode 1 is LDI (Rd = imm), opcode 3 is MOV (Rd = Ra). Any register, including R0, can be written.
- R5: Opcode 2 is ADD (Rd = Ra + Rb). The sum wraps modulo 256 and no flags are kept.
- R6: Opcode 0 and opcodes 6 to 15 change no register, and the program counter still advances by one.
- R7: Opcode 4 (OUT) sends Ra as a frame: one low start bit, eight data bits LSB first, then one high stop bit. The line idles high, and the core stays in EXECUTE until the frame has finished.
- R8: Each serial bit lasts baud_div_i + 1 clocks.
- R9: Opcode 5 (HLT) raises halted_o when its WRITEBACK ends, and halted_o stays high until reset. After that pc_o stays at the HLT address and no later instruction runs.
- R10: r7_o always shows R7. The default program ends with R7 = 8 after it has sent 0x38.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Lets the core leave idle after reset |
| baud_div_i | input | 16 | Serial bit period minus one, in clocks |
| r7_o | output | 8 | Current contents of R7 |
| pc_o | output | 5 | Program counter |
| halted_o | output | 1 | High once HLT has executed |
| tx_o | output | 1 | Serial output line, idles high |

## Verification
The default program is run twice, with divider values 3 and 7. The low run at the start of the received frame must scale with the divider, and the decoded byte must stay 0x38 in both runs. A short custom program covers four cases:
- an ADD that overflows, with R0 as one of the operands
- an undefined opcode whose Rd field points at R7
- a MOV into R7
- an instruction placed after HLT

Counting clocks from start_i to halted_o shows whether every instruction takes exactly four cycles. Holding start_i low after reset shows that the core does not run on its own.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int ROM_DEPTH = 32;
  localparam int INSTR_W   = 16;
  localparam int DATA_W    = 8;
  localparam int NUM_REGS  = 8;

  localparam logic [3:0] OP_NOP = 4'd0;
  localparam logic [3:0] OP_LDI = 4'd1;
  localparam logic [3:0] OP_ADD = 4'd2;
  localparam logic [3:0] OP_MOV = 4'd3;
  localparam logic [3:0] OP_OUT = 4'd4;
  localparam logic [3:0] OP_HLT = 4'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DECODE, ST_EXEC, ST_WB, ST_HALT
  } state_e;

  function automatic logic [15:0] enc_r(logic [3:0] op, logic [2:0] rd,
                                        logic [2:0] ra, logic [2:0] rb);
    return {op, rd, ra, rb, 3'b000};
  endfunction

  function automatic logic [15:0] enc_i(logic [3:0] op, logic [2:0] rd,
                                        logic [7:0] imm);
    return {op, rd, 1'b0, imm};
  endfunction

  function automatic logic [ROM_DEPTH*INSTR_W-1:0] default_prog();
    logic [ROM_DEPTH*INSTR_W-1:0] p;
    p = '0;
    p[ 0*16 +: 16] = enc_i(OP_LDI, 3'd1, 8'd1);
    p[ 1*16 +: 16] = enc_i(OP_LDI, 3'd2, 8'd1);
    p[ 2*16 +: 16] = enc_r(OP_ADD, 3'd3, 3'd1, 3'd2);
    p[ 3*16 +: 16] = enc_r(OP_ADD, 3'd4, 3'd2, 3'd3);
    p[ 4*16 +: 16] = enc_r(OP_ADD, 3'd5, 3'd3, 3'd4);
    p[ 5*16 +: 16] = enc_r(OP_ADD, 3'd6, 3'd4, 3'd5);
    p[ 6*16 +: 16] = enc_r(OP_MOV, 3'd7, 3'd6, 3'd0);
    p[ 7*16 +: 16] = enc_i(OP_LDI, 3'd5, 8'h30);
    p[ 8*16 +: 16] = enc_r(OP_ADD, 3'd4, 3'd7, 3'd5);
    p[ 9*16 +: 16] = enc_r(OP_OUT, 3'd0, 3'd4, 3'd0);
    p[10*16 +: 16] = enc_r(OP_HLT, 3'd0, 3'd0, 3'd0);
    return p;
  endfunction
endpackage

// File: rtl/mcu_rom.sv
module mcu_rom #(
  parameter int DEPTH  = 32,
  parameter int WIDTH  = 16,
  parameter logic [DEPTH*WIDTH-1:0] IMAGE = '0,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic [AW-1:0]    addr_i,
  output logic [WIDTH-1:0] data_o
);
  assign data_o = IMAGE[addr_i*WIDTH +: WIDTH];
endmodule

// File: rtl/mcu_regfile.sv
module mcu_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 8,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  output logic [DW-1:0] last_o
);
  logic [DW-1:0] rf_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) rf_q[i] <= '0;
    end else if (we_i) begin
      rf_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = rf_q[raddr_a_i];
  assign rdata_b_o = rf_q[raddr_b_i];
  assign last_o    = rf_q[NREGS-1];
endmodule

// File: rtl/mcu_uart_tx.sv
module mcu_uart_tx #(
  parameter int DW    = 8,
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             send_i,
  input  logic [DW-1:0]    data_i,
  output logic             busy_o,
  output logic             tx_o
);
  localparam int FRAME_W = DW + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic               busy_q;
  logic [FRAME_W-1:0] shift_q;
  logic [DIV_W-1:0]   div_q, tick_q;
  logic [CNT_W-1:0]   nbit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      shift_q <= '1;
      div_q   <= '0;
      tick_q  <= '0;
      nbit_q  <= '0;
    end else if (send_i && !busy_q) begin
      busy_q  <= 1'b1;
      shift_q <= {1'b1, data_i, 1'b0};
      div_q   <= div_i;
      tick_q  <= '0;
      nbit_q  <= '0;
    end else if (busy_q) begin
      if (tick_q == div_q) begin
        tick_q  <= '0;
        shift_q <= {1'b1, shift_q[FRAME_W-1:1]};
        if (nbit_q == CNT_W'(FRAME_W - 1)) busy_q <= 1'b0;
        else                               nbit_q <= nbit_q + 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = busy_q ? shift_q[0] : 1'b1;
endmodule

// File: rtl/mcu_core.sv
module mcu_core #(
  parameter int ROM_DEPTH = mcu_pkg::ROM_DEPTH,
  parameter int INSTR_W   = mcu_pkg::INSTR_W,
  parameter int DATA_W    = mcu_pkg::DATA_W,
  parameter int NUM_REGS  = mcu_pkg::NUM_REGS,
  parameter int DIV_W     = 16,
  parameter logic [ROM_DEPTH*INSTR_W-1:0] PROG = mcu_pkg::default_prog(),
  localparam int PC_W = $clog2(ROM_DEPTH),
  localparam int RA_W = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  baud_div_i,
  output logic [DATA_W-1:0] r7_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              halted_o,
  output logic              tx_o
);
  import mcu_pkg::*;

  localparam int RD_LSB = INSTR_W - 4 - RA_W;
  localparam int RA_LSB = RD_LSB - RA_W;
  localparam int RB_LSB = RA_LSB - RA_W;

  state_e              state_q;
  logic [PC_W-1:0]     pc_q;
  logic [INSTR_W-1:0]  ir_q, rom_data;
  logic [DATA_W-1:0]   opa_q, opb_q, res_q, rd_a, rd_b;
  logic                sent_q, tx_busy, tx_send, rf_we;

  logic [3:0]          op;
  logic [RA_W-1:0]     rd_f, ra_f, rb_f;
  logic [DATA_W-1:0]   imm_f;

  assign op    = ir_q[INSTR_W-1 -: 4];
  assign rd_f  = ir_q[RD_LSB +: RA_W];
  assign ra_f  = ir_q[RA_LSB +: RA_W];
  assign rb_f  = ir_q[RB_LSB +: RA_W];
  assign imm_f = ir_q[DATA_W-1:0];

  mcu_rom #(.DEPTH(ROM_DEPTH), .WIDTH(INSTR_W), .IMAGE(PROG)) u_rom (
    .addr_i (pc_q),
    .data_o (rom_data)
  );

  assign rf_we = (state_q == ST_WB) &&
                 (op == OP_LDI || op == OP_ADD || op == OP_MOV);

  mcu_regfile #(.NREGS(NUM_REGS), .DW(DATA_W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (rf_we),
    .waddr_i   (rd_f),
    .wdata_i   (res_q),
    .raddr_a_i (ra_f),
    .raddr_b_i (rb_f),
    .rdata_a_o (rd_a),
    .rdata_b_o (rd_b),
    .last_o    (r7_o)
  );

  assign tx_send = (state_q == ST_EXEC) && (op == OP_OUT) && !sent_q && !tx_busy;

  mcu_uart_tx #(.DW(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (baud_div_i),
    .send_i (tx_send),
    .data_i (opa_q),
    .busy_o (tx_busy),
    .tx_o   (tx_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      ir_q    <= '0;
      opa_q   <= '0;
      opb_q   <= '0;
      res_q   <= '0;
      sent_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (start_i) state_q <= ST_FETCH;
        ST_FETCH: begin
          ir_q    <= rom_data;
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          opa_q   <= rd_a;
          opb_q   <= rd_b;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (op == OP_OUT) begin
            // hold here until the frame has left the line
            if (!sent_q) begin
              if (!tx_busy) sent_q <= 1'b1;
            end else if (!tx_busy) begin
              sent_q  <= 1'b0;
              state_q <= ST_WB;
            end
          end else begin
            state_q <= ST_WB;
            case (op)
              OP_LDI:  res_q <= imm_f;
              OP_ADD:  res_q <= opa_q + opb_q;
              OP_MOV:  res_q <= opa_q;
              default: res_q <= res_q;
            endcase
          end
        end
        ST_WB: begin
          if (op == OP_HLT) begin
            state_q <= ST_HALT;
          end else begin
            pc_q    <= pc_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_HALT:   state_q <= ST_HALT;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign pc_o     = pc_q;
  assign halted_o = (state_q == ST_HALT);
endmodule

// File: rtl/mcu_core_chk.sv
module mcu_core_chk #(
  parameter int PC_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              halted_o,
  input logic              tx_o,
  input logic [PC_W-1:0]   pc_o,
  input mcu_pkg::state_e   state_q,
  input logic              tx_busy
);
  import mcu_pkg::*;

  AST_FETCH_THEN_DECODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH |=> state_q == ST_DECODE); // R1
  AST_DECODE_THEN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DECODE |=> state_q == ST_EXEC); // R1
  AST_EXEC_THEN_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_EXEC |=> (state_q == ST_EXEC || state_q == ST_WB)); // R1
  AST_PC_MOVES_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_o != $past(pc_o)) |-> ($past(state_q) == ST_WB && pc_o == $past(pc_o) + 1'b1)); // R1
  AST_IDLE_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE); // R3
  AST_TX_STALLS_CORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy |-> state_q == ST_EXEC); // R7
  AST_HALT_LINE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> tx_o); // R7
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o))); // R9
endmodule

bind mcu_core mcu_core_chk #(.PC_W(PC_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .halted_o (halted_o),
  .tx_o     (tx_o),
  .pc_o     (pc_o),
  .state_q  (state_q),
  .tx_busy  (tx_busy)
);

// File: tb/sim_mcu_core.sv
module sim_mcu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start1 = 1'b0;
  logic [15:0] baud = 16'd3;

  logic [7:0] r7_0, r7_1;
  logic [4:0] pc_0, pc_1;
  logic       halt_0, halt_1, tx_0, tx_1;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  // bench-side encoding: op[15:12] rd[11:9] ra[8:6] rb[5:3] imm[7:0]
  function automatic logic [15:0] ins(int op, int rd, int ra, int rb);
    return {op[3:0], rd[2:0], ra[2:0], rb[2:0], 3'b000};
  endfunction
  function automatic logic [15:0] insi(int op, int rd, int imm);
    return {op[3:0], rd[2:0], 1'b0, imm[7:0]};
  endfunction
  function automatic logic [511:0] test_prog();
    logic [511:0] p;
    p = '0;
    p[0*16 +: 16] = insi(1, 0, 'hF0);   // LDI R0
    p[1*16 +: 16] = insi(1, 1, 'h25);   // LDI R1
    p[2*16 +: 16] = ins(2, 2, 0, 1);    // ADD R2 = R0 + R1
    p[3*16 +: 16] = insi(15, 7, 'hFF);  // undefined, rd = R7
    p[4*16 +: 16] = ins(3, 7, 2, 0);    // MOV R7 = R2
    p[5*16 +: 16] = ins(5, 0, 0, 0);    // HLT
    p[6*16 +: 16] = insi(1, 7, 'hAA);   // never reached
    return p;
  endfunction

  mcu_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(1'b1), .baud_div_i(baud),
    .r7_o(r7_0), .pc_o(pc_0), .halted_o(halt_0), .tx_o(tx_0)
  );

  mcu_core #(.PROG(test_prog())) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start1), .baud_div_i(baud),
    .r7_o(r7_1), .pc_o(pc_1), .halted_o(halt_1), .tx_o(tx_1)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start1 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R2 u0 pc", pc_0, 0);
    check("R2 u0 r7", r7_0, 0);
    check("R2 u0 halted", halt_0, 0);
    check("R2 u0 tx", tx_0, 1);
    check("R2 u1 tx", tx_1, 1);
  endtask

  task automatic t_default_prog(input int div);
    logic smp [0:255];
    int   p, found, low;
    logic [7:0] rx;
    baud = div[15:0];
    p = div + 1;
    do_reset();
    found = 0;
    for (int i = 0; i < 400 && !found; i++) begin
      @(negedge clk);
      if (tx_0 == 1'b0) found = 1;
    end
    check("R7 start bit seen", found, 1);
    smp[0] = tx_0;
    for (int i = 1; i < 10 * p + 2; i++) begin
      @(negedge clk);
      smp[i] = tx_0;
      if (i == 9 * p + p / 2) check("R7 core stalled during frame", halt_0, 0);
    end
    low = 0;
    while (low < 200 && smp[low] == 1'b0) low++;
    check("R8 low run of 0x38 frame (4 bit times)", low, 4 * p);
    for (int b = 0; b < 8; b++) rx[b] = smp[(b + 1) * p + p / 2];
    check("R7 received byte", rx, 'h38);
    check("R7 stop bit", smp[9 * p + p / 2], 1);
    for (int i = 0; i < 100 && !halt_0; i++) @(negedge clk);
    check("R9 default halted", halt_0, 1);
    check("R10 r7 after default program", r7_0, 8);
    check("R9 pc at HLT", pc_0, 10);
    check("R7 line idle after halt", tx_0, 1);
  endtask

  task automatic t_custom_prog();
    do_reset();
    repeat (12) @(negedge clk);
    check("R3 pc held without start", pc_1, 0);
    check("R3 not halted without start", halt_1, 0);
    start1 = 1'b1;
    for (int n = 1; n <= 25; n++) begin
      @(negedge clk);
      if (n == 18) begin
        check("R6 undefined opcode left R7", r7_1, 0);
        check("R6 pc advanced past undefined", pc_1, 4);
      end
      if (n == 24) check("R1 not halted before 4-clock budget", halt_1, 0);
      if (n == 25) begin
        check("R1 R9 halted after 6 instr x 4 + 1", halt_1, 1);
        check("R4 R5 MOV of wrapped sum incl. R0", r7_1, 'h15);
        check("R9 pc at HLT address", pc_1, 5);
      end
    end
    repeat (40) @(negedge clk);
    check("R9 halted sticky", halt_1, 1);
    check("R9 no instruction after HLT", r7_1, 'h15);
    check("R9 pc frozen", pc_1, 5);
    check("R7 line idle when no OUT", tx_1, 1);
  endtask

  initial begin
    t_reset_state();
    t_default_prog(3);
    t_default_prog(7);
    t_custom_prog();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end
endmodule